// File: doc/BRIEF.md
# Banked SPI Register Access Engine

This block is an SPI master that performs single control-register accesses on an external network controller. The controller spreads its control registers over four banks and selects the bank with two bits of a common control register. The host hands the engine an 8-bit register address, a write flag and a data byte. The engine sends the bank-switch frames only when the cached bank differs from the one requested. It then runs the access frame and returns the read byte with a one-cycle done pulse.

Address bits 4:0 hold the register number, bits 6:5 hold the bank, and bit 7 marks the MAC/MII register class. A read from that class needs one extra dummy byte before valid data appears on the serial input. SCLK comes from the system clock through an even divider, CLK_DIV (default 4). Chip select stays low across every byte of a frame. It goes high for at least one SCLK period after every frame.

Top module: `bank_spi_engine`

## Requirements
- R1: The first byte of an access frame is {opcode[2:0], addr[4:0]}, with opcode 3'b000 for a read and 3'b010 for a write.
- R2: A write sends exactly two bytes in one chip-select frame: the command byte, then wdata_i.
- R3: A read with addr[7]=0 sends the command byte and one 0x00 byte in one frame. rdata_o equals the byte received during the second byte.
- R4: A read with addr[7]=1 sends the command byte and two 0x00 bytes. rdata_o equals the byte received during the third byte.
- R5: When addr[6:5] differs from the cached bank, two frames come before the access. The first is 0xBF,0x03, a bit-clear of both select bits in register 0x1F. The second is 0x9F,{6'b0,addr[6:5]}, a bit-set. After them the cache holds the new bank.
- R6: When addr[6:5] equals the cached bank, only the access frame is sent. Reset sets the cached bank to 0.
- R7: SPI mode 0, MSB first. SCLK idles low, is high for CLK_DIV/2 clock cycles per bit, and MOSI does not change while SCLK is high.
- R8: cs_no stays high for at least CLK_DIV clock cycles between two frames, and it is high when done_o pulses.
- R9: ack_o is high only in a cycle where req_i is high and the engine is idle. A request held while a transaction runs is not acknowledged.
- R10: done_o is a one-cycle pulse that ends every accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register address: class flag, bank, register |
| wdata_i | input | 8 | Write data |
| ack_o | output | 1 | Request accepted this cycle |
| done_o | output | 1 | Access finished pulse |
| rdata_o | output | 8 | Read result |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI serial out |
| miso_i | input | 1 | SPI serial in |

## Verification
A stale or wrong bank cache shows on the wire in the first request whose bank differs from the true bank. That request either lacks the clear/set frame pair or carries one it should not have. A wrong byte counter or class decode changes the number of bytes in the access frame, so rdata_o returns the wrong response byte within the same request. Divider or shift errors break the bit timing or the byte values on the first frame after reset.

// File: rtl/bank_spi_pkg.sv
package bank_spi_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 5;
  localparam int BANK_W = 2;
  localparam int BANK_LSB = REG_W;
  localparam int CLASS_BIT = ADDR_W - 1;
  localparam int OPC_W = DATA_W - REG_W;

  localparam logic [OPC_W-1:0] OPC_RD   = 3'b000;
  localparam logic [OPC_W-1:0] OPC_WR   = 3'b010;
  localparam logic [OPC_W-1:0] OPC_BSET = 3'b100;
  localparam logic [OPC_W-1:0] OPC_BCLR = 3'b101;
  localparam logic [REG_W-1:0] SEL_REG  = 5'h1F;
  localparam logic [DATA_W-1:0] SEL_MASK = DATA_W'((1 << BANK_W) - 1);

  typedef enum logic [1:0] {FR_CLR, FR_SET, FR_ACC} frame_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_GAP} seq_st_e;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int CLK_DIV = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_i,
  output logic [DATA_W-1:0] rx_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = $clog2(DATA_W);

  logic              busy_q;
  logic [CW-1:0]     div_q;
  logic [BW-1:0]     bit_q;
  logic              sclk_q;
  logic              done_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          tx_q   <= tx_i;
          div_q  <= '0;
          bit_q  <= '0;
          sclk_q <= 1'b0;
        end
      end else if (div_q == CW'(HALF - 1)) begin
        div_q <= '0;
        if (!sclk_q) begin
          // rising edge: sample input
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[DATA_W-2:0], miso_i};
        end else begin
          // falling edge: advance output
          sclk_q <= 1'b0;
          if (bit_q == BW'(DATA_W - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign rx_o   = rx_q;
  assign done_o = done_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[DATA_W-1];
endmodule

// File: rtl/frame_byte_builder.sv
module frame_byte_builder
  import bank_spi_pkg::*;
(
  input  frame_e            frame_i,
  input  logic [1:0]        idx_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              last_o
);
  logic [1:0] n_last;

  always_comb begin
    byte_o = '0;
    n_last = 2'd1;
    unique case (frame_i)
      FR_CLR: byte_o = (idx_i == 2'd0) ? {OPC_BCLR, SEL_REG} : SEL_MASK;
      FR_SET: byte_o = (idx_i == 2'd0) ? {OPC_BSET, SEL_REG}
                                       : DATA_W'(addr_i[BANK_LSB +: BANK_W]);
      FR_ACC: begin
        if (wr_i) begin
          byte_o = (idx_i == 2'd0) ? {OPC_WR, addr_i[REG_W-1:0]} : wdata_i;
        end else begin
          byte_o = (idx_i == 2'd0) ? {OPC_RD, addr_i[REG_W-1:0]} : '0;
          // class registers need one dummy byte before valid data
          if (addr_i[CLASS_BIT]) n_last = 2'd2;
        end
      end
      default: byte_o = '0;
    endcase
    last_o = (idx_i == n_last);
  end
endmodule

// File: rtl/bank_access_seq.sv
module bank_access_seq
  import bank_spi_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cs_no,
  output logic              start_o,
  output logic [DATA_W-1:0] tx_o,
  input  logic              byte_done_i,
  input  logic [DATA_W-1:0] rx_i
);
  localparam int GW = $clog2(CLK_DIV + 1);

  seq_st_e           st_q;
  frame_e            frame_q;
  logic [1:0]        idx_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BANK_W-1:0] bank_q;
  logic [GW-1:0]     gap_q;
  logic              cs_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              last;
  logic [BANK_W-1:0] req_bank;

  assign req_bank = addr_i[BANK_LSB +: BANK_W];
  assign ack_o    = req_i && (st_q == ST_IDLE);
  assign start_o  = (st_q == ST_LOAD);

  frame_byte_builder u_build (
    .frame_i (frame_q),
    .idx_i   (idx_q),
    .wr_i    (wr_q),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .byte_o  (tx_o),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      frame_q <= FR_ACC;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      bank_q  <= '0;
      gap_q   <= '0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            wr_q    <= wr_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            frame_q <= (req_bank != bank_q) ? FR_CLR : FR_ACC;
            idx_q   <= '0;
            cs_q    <= 1'b0;
            st_q    <= ST_LOAD;
          end
        end
        ST_LOAD: st_q <= ST_SHIFT;
        ST_SHIFT: begin
          if (byte_done_i) begin
            if (last) begin
              cs_q  <= 1'b1;
              gap_q <= '0;
              st_q  <= ST_GAP;
              if (frame_q == FR_ACC) rdata_q <= rx_i;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_LOAD;
            end
          end
        end
        ST_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GW'(CLK_DIV - 1)) begin
            idx_q <= '0;
            unique case (frame_q)
              FR_CLR: begin
                frame_q <= FR_SET;
                cs_q    <= 1'b0;
                st_q    <= ST_LOAD;
              end
              FR_SET: begin
                bank_q  <= addr_q[BANK_LSB +: BANK_W];
                frame_q <= FR_ACC;
                cs_q    <= 1'b0;
                st_q    <= ST_LOAD;
              end
              default: begin
                done_q <= 1'b1;
                st_q   <= ST_IDLE;
              end
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no   = cs_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/bank_spi_engine.sv
module bank_spi_engine
  import bank_spi_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        wr_i,
  input  logic [7:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic        ack_o,
  output logic        done_o,
  output logic [7:0]  rdata_o,
  output logic        sclk_o,
  output logic        cs_no,
  output logic        mosi_o,
  input  logic        miso_i
);
  logic              start;
  logic              byte_done;
  logic [DATA_W-1:0] tx_byte;
  logic [DATA_W-1:0] rx_byte;

  bank_access_seq #(.CLK_DIV(CLK_DIV)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .ack_o       (ack_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o),
    .cs_no       (cs_no),
    .start_o     (start),
    .tx_o        (tx_byte),
    .byte_done_i (byte_done),
    .rx_i        (rx_byte)
  );

  spi_byte_shifter #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .tx_i    (tx_byte),
    .rx_o    (rx_byte),
    .done_o  (byte_done),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .miso_i  (miso_i)
  );
endmodule

// File: rtl/bank_spi_engine_chk.sv
module bank_spi_engine_chk #(
  parameter int CLK_DIV = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic ack_o,
  input logic done_o,
  input logic sclk_o,
  input logic cs_no,
  input logic mosi_o
);
  logic [15:0] hi_cnt;
  logic        seen_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt     <= '0;
      seen_frame <= 1'b0;
    end else begin
      if (!cs_no) seen_frame <= 1'b1;
      if (cs_no) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
      else       hi_cnt <= '0;
    end
  end

  assert_sclk_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  assert_mosi_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  assert_cs_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) && seen_frame) |-> (hi_cnt >= 16'(CLK_DIV)));
  assert_done_cs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_no);
  assert_ack_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> req_i);
  assert_ack_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind bank_spi_engine bank_spi_engine_chk #(.CLK_DIV(CLK_DIV)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .ack_o  (ack_o),
  .done_o (done_o),
  .sclk_o (sclk_o),
  .cs_no  (cs_no),
  .mosi_o (mosi_o)
);

// File: tb/bank_spi_engine_tb_top.sv
module bank_spi_engine_tb_top;
  localparam int CLK_DIV = 4;

  typedef struct packed {
    logic       wr;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] r1;
    logic [7:0] r2;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h05, 8'h00, 8'h5A, 8'h11},
    '{1'b1, 8'h45, 8'h3C, 8'h00, 8'h00},
    '{1'b0, 8'hD2, 8'h00, 8'h77, 8'hC3},
    '{1'b0, 8'h33, 8'h00, 8'h96, 8'h22},
    '{1'b1, 8'h7F, 8'hA5, 8'h00, 8'h00},
    '{1'b0, 8'hE0, 8'h00, 8'h01, 8'hFE},
    '{1'b1, 8'h1A, 8'h81, 8'h00, 8'h00},
    '{1'b0, 8'hA4, 8'h00, 8'h6B, 8'h4D}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, wr = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       ack, done, sclk, cs_n, mosi;
  logic [7:0] rdata;
  logic       miso = 1'b0;

  always #2.5 clk = ~clk;

  bank_spi_engine #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .done_o(done), .rdata_o(rdata),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [1:0] tb_bank = '0;

  // slave model, sampled mid-cycle
  logic [7:0] resp [3];
  int         fr_n;
  int         fr_len [8];
  logic [7:0] fr_b [8][4];
  logic [7:0] sh;
  int         bitn, out_cnt, hi_run, min_gap, sclk_hi, sclk_bad;
  logic       p_cs = 1'b1, p_sclk = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (p_cs && !cs_n) begin
      if (fr_n > 0 && hi_run < min_gap) min_gap = hi_run;
      bitn = 0; out_cnt = 0;
      if (fr_n < 8) fr_len[fr_n] = 0;
      miso = resp[0][7];
    end
    if (!cs_n && !p_sclk && sclk) begin
      sh = {sh[6:0], mosi};
      bitn++;
      sclk_hi = 0;
      if (bitn == 8) begin
        bitn = 0;
        if (fr_n < 8 && fr_len[fr_n] < 4) fr_b[fr_n][fr_len[fr_n]] = sh;
        if (fr_n < 8) fr_len[fr_n]++;
      end
    end
    if (sclk) sclk_hi++;
    if (!cs_n && p_sclk && !sclk) begin
      if (sclk_hi != CLK_DIV / 2) sclk_bad++;
      out_cnt++;
      if (out_cnt < 24) miso = resp[out_cnt / 8][7 - (out_cnt % 8)];
    end
    if (!p_cs && cs_n) fr_n++;
    hi_run = cs_n ? hi_run + 1 : 0;
    p_cs = cs_n; p_sclk = sclk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    finish_run();
  end

  task automatic clear_log(input logic [7:0] r1, input logic [7:0] r2);
    fr_n = 0; min_gap = 1000; sclk_bad = 0;
    resp[0] = 8'hEE; resp[1] = r1; resp[2] = r2;
  endtask

  task automatic run_req(input vec_t v, input bit chk_gap, output logic [7:0] got);
    int t;
    clear_log(v.r1, v.r2);
    @(negedge clk);
    req = 1'b1; wr = v.wr; addr = v.addr; wdata = v.wdata;
    #0.5;
    check(ack == 1'b1, "R9 ack when idle", ack, 1);
    @(negedge clk);
    req = 1'b0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    check(done == 1'b1, "R10 done pulse", done, 1);
    check(cs_n == 1'b1, "R8 cs high at done", cs_n, 1);
    got = rdata;
    @(negedge clk);
    check(done == 1'b0, "R10 done one cycle", done, 0);
    check(sclk_bad == 0, "R7 sclk high time", sclk_bad, 0);
    if (chk_gap) check(min_gap >= CLK_DIV, "R8 cs gap", min_gap, CLK_DIV);
  endtask

  task automatic check_frames(input vec_t v);
    int base;
    logic [1:0] nb;
    bit sw;
    nb = v.addr[6:5];
    sw = (nb != tb_bank);
    base = sw ? 2 : 0;
    check(fr_n == base + 1, sw ? "R5 frame count" : "R6 frame count", fr_n, base + 1);
    if (sw) begin
      check(fr_len[0] == 2 && fr_b[0][0] == 8'hBF && fr_b[0][1] == 8'h03,
            "R5 clear frame", {fr_b[0][0], fr_b[0][1]}, 16'hBF03);
      check(fr_len[1] == 2 && fr_b[1][0] == 8'h9F && fr_b[1][1] == {6'b0, nb},
            "R5 set frame", {fr_b[1][0], fr_b[1][1]}, {8'h9F, 6'b0, nb});
      tb_bank = nb;
    end
    check(fr_b[base][0] == {v.wr ? 3'b010 : 3'b000, v.addr[4:0]},
          "R1 command byte", fr_b[base][0], {v.wr ? 3'b010 : 3'b000, v.addr[4:0]});
    if (v.wr) begin
      check(fr_len[base] == 2 && fr_b[base][1] == v.wdata, "R2 write frame",
            fr_b[base][1], v.wdata);
    end else if (v.addr[7]) begin
      check(fr_len[base] == 3 && fr_b[base][1] == 0 && fr_b[base][2] == 0,
            "R4 dummy byte frame", fr_len[base], 3);
    end else begin
      check(fr_len[base] == 2 && fr_b[base][1] == 0, "R3 read frame", fr_len[base], 2);
    end
  endtask

  initial begin
    logic [7:0] got;
    vec_t v;
    int t;
    clear_log(8'h00, 8'h00);
    repeat (3) @(negedge clk);
    check(cs_n == 1 && sclk == 0 && done == 0 && ack == 0, "R7 reset idle",
          {cs_n, sclk, done, ack}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_req(VEC[i], VEC[i].addr[6:5] != tb_bank, got);
      check_frames(VEC[i]);
      if (!VEC[i].wr) begin
        if (VEC[i].addr[7]) check(got == VEC[i].r2, "R4 read data", got, VEC[i].r2);
        else                check(got == VEC[i].r1, "R3 read data", got, VEC[i].r1);
      end
    end

    // R9: request held while busy is not acknowledged
    v = '{1'b0, 8'h25, 8'h00, 8'h3E, 8'h00};
    clear_log(v.r1, v.r2);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = v.addr;
    @(negedge clk);
    addr = 8'h65; wr = 1'b1;
    for (int k = 0; k < 12; k++) begin
      #0.5;
      check(ack == 1'b0, "R9 no ack while busy", ack, 0);
      @(negedge clk);
    end
    req = 1'b0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    check(rdata == v.r1, "R9 first request data", rdata, v.r1);
    @(negedge clk);
    check(fr_n == 1 && fr_b[0][0] == 8'h05, "R9 busy request dropped", fr_n, 1);
    repeat (20) @(negedge clk);
    check(fr_n == 1 && cs_n == 1, "R9 no later frame", fr_n, 1);

    // R6: reset returns the cached bank to 0
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tb_bank = 2'd0;
    @(negedge clk);
    v = '{1'b0, 8'h9C, 8'h00, 8'h12, 8'hB7};
    run_req(v, 1'b0, got);
    check(fr_n == 1, "R6 no switch after reset", fr_n, 1);
    check(got == v.r2, "R4 read data after reset", got, v.r2);

    // R6: same bank twice, second access has no switch
    v = '{1'b1, 8'h6E, 8'h44, 8'h00, 8'h00};
    run_req(v, 1'b1, got);
    check_frames(v);
    run_req(v, 1'b0, got);
    check(fr_n == 1, "R6 repeated bank", fr_n, 1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule